// File: doc/BRIEF.md
# SPI Command-Decoding NAND Bridge

This block is an SPI slave (mode 0: clock idles low, data sampled on the rising edge, eight-bit words, most significant bit first) that lets a host reach three things through one serial link: a parallel eight-bit NAND data port, an eight-bit configuration register whose bits drive output pins, and one LED output controlled by its own commands. It runs entirely in the system clock domain. The serial clock, chip select and data lines are synchronised and their edges detected, so the serial clock must be slower than the system clock. With the default two-stage synchroniser, each serial clock half period must last at least eight system clocks.

The first byte after chip select falls is an opcode, and it selects the rest of the transaction:
- 0x08 switches the payload to two bits per serial clock and streams bytes to the NAND port with a write strobe.
- 0x09 loads the configuration register from the next byte.
- 0x0A and 0x0B return NAND read data on the serial output after one or four dummy bytes.
- 0x0C and 0x0D switch the LED output on and off.

Raising chip select ends any transaction.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset, `cfg_o` is 0x1F (bits 0-3 active-low LED enables, bit 4 active-low NAND chip enable, bits 5-7 general outputs), `led_o` is 0, both NAND strobes are low and `spi_miso_o` is 0.
- R2: Bits are taken on rising serial clock edges, most significant bit first, and the first complete byte after chip select falls is the opcode.
- R3: Opcode 0x09 writes the following byte into `cfg_o`; any further bytes in the same transaction leave it unchanged.
- R4: Opcode 0x0C sets `led_o` to 1 and opcode 0x0D clears it, without touching `cfg_o`.
- R5: After opcode 0x08, each payload byte takes four serial clocks. On each clock `spi_mosi_i` carries the higher (odd) bit and `spi_sio1_i` carries the lower (even) bit of the pair. Each accepted byte appears on `nand_wdata_o` with a `nand_we_o` pulse.
- R6: The last dual-line byte before chip select rises is a trailing dummy and produces no write strobe.
- R7: After opcode 0x0A and one dummy byte, each later byte slot shifts out a NAND byte on `spi_miso_o`, most significant bit first and changing after falling clock edges. `nand_re_o` pulses at the end of every byte from the last dummy on, and `nand_rdata_i` is taken in the cycle after the pulse.
- R8: Opcode 0x0B behaves like 0x0A but has four dummy bytes before read data.
- R9: Raising chip select aborts any transaction, including a partial byte. The next transaction starts again at the opcode.
- R10: An unknown opcode causes every remaining byte of its transaction to be ignored: no register change and no strobes.
- R11: `nand_we_o` and `nand_re_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from the host |
| spi_csn_i | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Host-to-slave data, odd bit in dual mode |
| spi_sio1_i | input | 1 | Second data line, even bit in dual mode |
| spi_miso_o | output | 1 | Slave-to-host data |
| cfg_o | output | 8 | Configuration register outputs |
| led_o | output | 1 | Separately commanded LED output, 1 = on |
| nand_wdata_o | output | 8 | NAND write data |
| nand_we_o | output | 1 | NAND write strobe |
| nand_re_o | output | 1 | NAND read strobe |
| nand_rdata_i | input | 8 | NAND read data |

## Verification
A bit counter out of step, or the wrong line width, mangles the very next byte. That shows up as a wrong `cfg_o` value or wrong write data at the end of the first payload byte. A phase or dummy-count error moves read data by whole bytes on `spi_miso_o` and changes the number of `nand_re_o` pulses, both visible within one transaction. A missing reset on chip-select rise appears in the following transaction, where the opcode is misread and the LED or configuration outputs fail to change.

// File: rtl/spi_nand_pkg.sv
package spi_nand_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_WR_DUAL = 8'h08;
  localparam logic [BYTE_W-1:0] OPC_CFG     = 8'h09;
  localparam logic [BYTE_W-1:0] OPC_RD      = 8'h0A;
  localparam logic [BYTE_W-1:0] OPC_RD_LONG = 8'h0B;
  localparam logic [BYTE_W-1:0] OPC_LED_ON  = 8'h0C;
  localparam logic [BYTE_W-1:0] OPC_LED_OFF = 8'h0D;

  typedef enum logic [2:0] {
    PH_OPC, PH_CFG, PH_IGN, PH_WR, PH_DUMMY, PH_RD
  } phase_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic d0_i,
  input  logic d1_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_act_o,
  output logic d0_o,
  output logic d1_o
);
  localparam logic [3:0] IDLE = 4'b0100; // {sclk, csn, d1, d0}

  logic [3:0] pipe_q [STAGES];
  logic       sclk_prev_q;
  logic [3:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= IDLE;
      sclk_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= {sclk_i, csn_i, d1_i, d0_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sclk_prev_q <= pipe_q[STAGES-1][3];
    end
  end

  assign last     = pipe_q[STAGES-1];
  assign cs_act_o = !last[2];
  assign rise_o   = cs_act_o && last[3] && !sclk_prev_q;
  assign fall_o   = cs_act_o && !last[3] && sclk_prev_q;
  assign d1_o     = last[1];
  assign d0_o     = last[0];
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_nand_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              d0_i,
  input  logic              d1_i,
  input  logic              dual_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              miso_o
);
  localparam int CW = $clog2(BYTE_W);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] rx_q, rx_nxt, tx_q, pend_byte_q;
  logic              pend_q;
  logic [CW-1:0]     last_cnt;

  assign rx_nxt   = dual_i ? {rx_q[BYTE_W-3:0], d0_i, d1_i} : {rx_q[BYTE_W-2:0], d0_i};
  assign last_cnt = dual_i ? CW'(BYTE_W/2 - 1) : CW'(BYTE_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; rx_q <= '0; tx_q <= '0; pend_q <= 1'b0;
      pend_byte_q <= '0; byte_vld_o <= 1'b0; byte_o <= '0;
    end else if (!cs_act_i) begin
      cnt_q <= '0; tx_q <= '0; pend_q <= 1'b0; byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (rise_i) begin
        rx_q <= rx_nxt;
        if (cnt_q == last_cnt) begin
          cnt_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= rx_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (fall_i) begin
        if (pend_q) begin
          tx_q   <= pend_byte_q;
          pend_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (load_i) begin
        pend_q      <= 1'b1;
        pend_byte_q <= load_byte_i;
      end
    end
  end

  assign miso_o = tx_q[BYTE_W-1];

  a_r5_dual_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |-> cnt_q < CW'(BYTE_W/2));
  a_r9_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (cnt_q == '0 && !byte_vld_o));
endmodule

// File: rtl/spi_nand_ctrl.sv
module spi_nand_ctrl
  import spi_nand_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'h1F,
  parameter int                SHORT_DUMMY = 1,
  parameter int                LONG_DUMMY  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] nand_rdata_i,
  output logic              dual_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] load_byte_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic              led_o,
  output logic [BYTE_W-1:0] nand_wdata_o,
  output logic              nand_we_o,
  output logic              nand_re_o
);
  localparam int DW = $clog2(LONG_DUMMY + 1);

  phase_e            phase_q;
  logic [DW-1:0]     dcnt_q;
  logic              hold_vld_q, re_d1_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OPC; dcnt_q <= '0; hold_vld_q <= 1'b0; hold_q <= '0;
      cfg_o <= CFG_RST; led_o <= 1'b0; nand_wdata_o <= '0;
      nand_we_o <= 1'b0; nand_re_o <= 1'b0; re_d1_q <= 1'b0;
    end else begin
      re_d1_q <= nand_re_o;
      if (!cs_act_i) begin
        phase_q <= PH_OPC; hold_vld_q <= 1'b0;
        nand_we_o <= 1'b0; nand_re_o <= 1'b0;
      end else begin
        nand_we_o <= 1'b0;
        nand_re_o <= 1'b0;
        if (byte_vld_i) begin
          unique case (phase_q)
            PH_OPC: begin
              unique case (byte_i)
                OPC_WR_DUAL: phase_q <= PH_WR;
                OPC_CFG:     phase_q <= PH_CFG;
                OPC_RD:      begin dcnt_q <= DW'(SHORT_DUMMY - 1); phase_q <= PH_DUMMY; end
                OPC_RD_LONG: begin dcnt_q <= DW'(LONG_DUMMY - 1);  phase_q <= PH_DUMMY; end
                OPC_LED_ON:  begin led_o <= 1'b1; phase_q <= PH_IGN; end
                OPC_LED_OFF: begin led_o <= 1'b0; phase_q <= PH_IGN; end
                default:     phase_q <= PH_IGN;
              endcase
            end
            PH_CFG: begin
              cfg_o   <= byte_i;
              phase_q <= PH_IGN;
            end
            PH_WR: begin
              // one-byte lag: the final byte before deselect is the dummy
              if (hold_vld_q) begin
                nand_wdata_o <= hold_q;
                nand_we_o    <= 1'b1;
              end
              hold_q     <= byte_i;
              hold_vld_q <= 1'b1;
            end
            PH_DUMMY: begin
              if (dcnt_q == '0) begin
                nand_re_o <= 1'b1;
                phase_q   <= PH_RD;
              end else begin
                dcnt_q <= dcnt_q - 1'b1;
              end
            end
            PH_RD:   nand_re_o <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign dual_o      = (phase_q == PH_WR);
  assign load_o      = re_d1_q;
  assign load_byte_o = nand_rdata_i;

  a_r11_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_we_o |=> !nand_we_o);
  a_r11_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_re_o |=> !nand_re_o);
  a_r3_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(cfg_o));
  a_r4_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(led_o));
  a_r9_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (!nand_we_o && !nand_re_o));
endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import spi_nand_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'h1F,
  parameter int                SHORT_DUMMY = 1,
  parameter int                LONG_DUMMY  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_csn_i,
  input  logic              spi_mosi_i,
  input  logic              spi_sio1_i,
  output logic              spi_miso_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic              led_o,
  output logic [BYTE_W-1:0] nand_wdata_o,
  output logic              nand_we_o,
  output logic              nand_re_o,
  input  logic [BYTE_W-1:0] nand_rdata_i
);
  logic rise, fall, cs_act, d0, d1, dual, load, byte_vld;
  logic [BYTE_W-1:0] load_byte, rx_byte;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i(spi_sclk_i), .csn_i(spi_csn_i),
    .d0_i(spi_mosi_i), .d1_i(spi_sio1_i),
    .rise_o(rise), .fall_o(fall), .cs_act_o(cs_act), .d0_o(d0), .d1_o(d1)
  );

  spi_shift u_shift (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .rise_i(rise), .fall_i(fall),
    .d0_i(d0), .d1_i(d1), .dual_i(dual), .load_i(load), .load_byte_i(load_byte),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .miso_o(spi_miso_o)
  );

  spi_nand_ctrl #(
    .CFG_RST(CFG_RST), .SHORT_DUMMY(SHORT_DUMMY), .LONG_DUMMY(LONG_DUMMY)
  ) u_ctrl (
    .clk_i, .rst_ni, .cs_act_i(cs_act), .byte_vld_i(byte_vld), .byte_i(rx_byte),
    .nand_rdata_i, .dual_o(dual), .load_o(load), .load_byte_o(load_byte),
    .cfg_o, .led_o, .nand_wdata_o, .nand_we_o, .nand_re_o
  );
endmodule

// File: tb/spi_nand_bridge_tb.sv
module spi_nand_bridge_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, sio1 = 1'b0;
  logic miso, led, we, re;
  logic [7:0] cfg, wdata, rdata = 8'h00;
  int checks = 0, fails = 0;
  int wcnt = 0, rcnt = 0;
  logic [7:0] wlog [16];

  always #10 clk = ~clk;

  spi_nand_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
    .spi_mosi_i(mosi), .spi_sio1_i(sio1), .spi_miso_o(miso), .cfg_o(cfg),
    .led_o(led), .nand_wdata_o(wdata), .nand_we_o(we), .nand_re_o(re),
    .nand_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      if (wcnt < 16) wlog[wcnt] <= wdata;
      wcnt <= wcnt + 1;
    end
    if (re) begin
      rdata <= 8'hC0 + 8'(rcnt);
      rcnt  <= rcnt + 1;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    csn = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF); csn = 1'b1; wait_clk(4 * HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic spi_dual(input logic [7:0] tx);
    for (int k = 0; k < 4; k++) begin
      mosi = tx[7-2*k]; sio1 = tx[6-2*k];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    sio1 = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg, 8'h1F);
    check("R1 led", led, 0);
    check("R1 strobes", {we, re}, 0);
    check("R1 miso", miso, 0);
  endtask

  task automatic t_cfg();
    logic [7:0] r;
    cs_low(); spi_byte(8'h09, r); spi_byte(8'hA5, r); spi_byte(8'h3C, r); cs_high();
    check("R2 R3 cfg msb-first load, extra byte ignored", cfg, 8'hA5);
  endtask

  task automatic t_led();
    logic [7:0] r;
    cs_low(); spi_byte(8'h0C, r); cs_high();
    check("R4 led on", led, 1);
    check("R4 cfg untouched", cfg, 8'hA5);
    cs_low(); spi_byte(8'h0D, r); cs_high();
    check("R4 led off", led, 0);
  endtask

  task automatic t_dual_write();
    logic [7:0] r;
    int w0;
    w0 = wcnt;
    cs_low(); spi_byte(8'h08, r);
    spi_dual(8'h3C); spi_dual(8'hA7); spi_dual(8'h5E); spi_dual(8'hFF);
    cs_high();
    check("R5 R6 write count", wcnt - w0, 3);
    check("R5 byte0", wlog[w0], 8'h3C);
    check("R5 byte1", wlog[w0+1], 8'hA7);
    check("R5 byte2", wlog[w0+2], 8'h5E);
  endtask

  task automatic t_read(input logic [7:0] opc, input int ndummy, input int ndata, input string req);
    logic [7:0] r;
    int p0;
    p0 = rcnt;
    cs_low(); spi_byte(opc, r);
    for (int i = 0; i < ndummy; i++) spi_byte(8'h00, r);
    for (int j = 0; j < ndata; j++) begin
      spi_byte(8'h00, r);
      check(req, r, 8'hC0 + 8'(p0 + j));
    end
    cs_high();
    check(req, rcnt - p0, ndata + 1);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int w0;
    w0 = wcnt;
    cs_low(); spi_byte(8'h08, r); spi_dual(8'h11); cs_high();
    check("R6 R9 lone dual byte dropped", wcnt - w0, 0);
    cs_low(); spi_bits(8'hF0, 4, r); cs_high();
    cs_low(); spi_byte(8'h0C, r); cs_high();
    check("R9 opcode after partial byte", led, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    int w0, p0;
    w0 = wcnt; p0 = rcnt;
    cs_low(); spi_byte(8'h55, r); spi_byte(8'h09, r); spi_byte(8'h00, r); spi_byte(8'h0D, r); cs_high();
    check("R10 cfg unchanged", cfg, 8'hA5);
    check("R10 led unchanged", led, 1);
    check("R10 no strobes", (wcnt - w0) + (rcnt - p0), 0);
  endtask

  bit done = 1'b0;

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_cfg();
    t_led();
    t_dual_write();
    t_read(8'h0A, 1, 3, "R7 R11 short read");
    t_read(8'h0B, 4, 2, "R8 long read");
    t_abort();
    t_unknown();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule